// File: doc/BRIEF.md
# Serial Flash Slave Command Interface

This block is the device-side front end of a small serial flash memory. The bus has four signals: a chip select (active low), a serial clock, a serial data input and a serial data output. The block samples all of them with its own system clock. It assembles 8-bit bus cycles and decodes them into five operations against an internal byte array:
- read
- byte program
- sector erase
- chip erase
- status read

Program and erase do not change the array at once. Each starts a busy period of a fixed number of system clocks, and the change is applied when that period ends. Software can poll a status byte whose bit 0 shows the busy state.

A host drives the bus in mode 0. The clock idles low, input bits are sampled on rising edges, and output bits change on falling edges. A write-protect pin blocks every program and erase. A device-reset pin returns the block to standby and cancels any program or erase that has not yet been applied.

The array is sized by two parameters: the number of bytes per sector and the number of sectors, both powers of two. The address wraps at the top of the array.

Top module: `sfl_slave`

## Requirements
- R1: Every bus cycle is 8 bits. Bits are taken most significant first, on rising serial-clock edges while select is low. The first byte after select falls is the opcode: 03h read, 02h byte program, 20h sector erase, 60h chip erase, 05h status read.
- R2: Read (03h) is followed by three address bytes, most significant first. Only the low address bits that index the array are used. The byte at that address comes out MSB first, and its first bit is driven on the falling clock edge that follows the last address bit.
- R3: During a read, the address advances by one for each byte sent. After the top address (size minus 1) it continues at address 0, and the stream runs until select rises.
- R4: Byte program (02h) is followed by three address bytes and one data byte. The data is written only if the target byte holds FFh when the busy period ends. Otherwise the array is left unchanged.
- R5: Sector erase (20h) is followed by three address bytes. It sets to FFh every byte whose address bits above the in-sector offset match those of the given address. No other byte changes.
- R6: Chip erase (60h) takes no address and sets every byte to FFh.
- R7: Status read (05h) returns the byte {0000000b, busy}. The same byte repeats for as long as the clock keeps running, and its value follows the current busy state.
- R8: An accepted program or erase makes the block busy for BUSY_CYC system clocks, and takes effect when that count ends. While busy, read, program and erase opcodes are ignored and only status read is served.
- R9: While the write-protect input is low, program and erase commands are ignored. No busy period starts and the array is unchanged.
- R10: If select rises before a command's last byte is complete, the command has no effect.
- R11: An unknown opcode, and any byte after a command's last byte, is ignored until select rises. The output enable stays low throughout.
- R12: The output enable is low whenever select is high. Pulling the device-reset input low returns the block to standby: it clears busy and discards any pending program or erase.
- R13: After power-on reset, every array byte is FFh, the block is not busy, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out; valid only while so_oe is high |
| so_oe | output | 1 | Output enable for the serial data pin |
| wp_n | input | 1 | Write protect, active low |
| dev_rst_n | input | 1 | Device reset to standby, active low |

## Verification
The busy count can run out in the same system clock in which a falling serial-clock edge loads the next status byte into the output shifter. The bench provokes this by starting a program and then keeping one status read running for several hundred clocks, so that the stream spans the end of the busy period. The result is judged by three rules:
- every status byte must be 01h or 00h;
- the stream must never go back from 00h to 01h;
- the first byte must be 01h and the last byte 00h.

A second overlap, device reset arriving while a program is still pending, is judged at the port: a later read must return the untouched FFh.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_SERASE = 8'h20;
  localparam logic [7:0] OPC_CERASE = 8'h60;
  localparam logic [7:0] OPC_STAT   = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_STAT,
    ST_IGN
  } cmd_st_e;

  typedef enum logic [1:0] {
    JOB_NONE,
    JOB_PROG,
    JOB_SECT,
    JOB_CHIP
  } job_e;

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       cs_s,
  input  logic       si_s,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       tx_load,
  output logic       so
);

  logic       sck_q, cs_q;
  logic       rise, fall;
  logic [2:0] bcnt_q, bcnt_d;
  logic [6:0] sh_q, sh_d;
  logic [7:0] txd_q, txd_d;
  logic [2:0] tcnt_q, tcnt_d;
  logic       so_q, so_d;

  assign rise    = sck_s & ~sck_q & ~cs_s;
  assign fall    = ~sck_s & sck_q & ~cs_s;
  assign cs_fall = ~cs_s & cs_q;
  assign cs_rise = cs_s & ~cs_q;

  assign byte_vld = rise && (bcnt_q == 3'd7);
  assign byte_out = {sh_q, si_s};
  assign tx_load  = fall && tx_en && (tcnt_q == 3'd0);
  assign so       = so_q;

  always_comb begin
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    txd_d  = txd_q;
    tcnt_d = tcnt_q;
    so_d   = so_q;
    if (cs_fall) begin
      bcnt_d = 3'd0;
      tcnt_d = 3'd0;
      so_d   = 1'b0;
    end else begin
      if (rise) begin
        bcnt_d = bcnt_q + 3'd1;
        sh_d   = {sh_q[5:0], si_s};
      end
      if (fall && tx_en) begin
        if (tcnt_q == 3'd0) begin
          so_d   = tx_byte[7];
          txd_d  = {tx_byte[6:0], 1'b0};
          tcnt_d = 3'd7;
        end else begin
          so_d   = txd_q[7];
          txd_d  = {txd_q[6:0], 1'b0};
          tcnt_d = tcnt_q - 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      bcnt_q <= 3'd0;
      sh_q   <= 7'd0;
      txd_q  <= 8'd0;
      tcnt_q <= 3'd0;
      so_q   <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_s;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
      tcnt_q <= tcnt_d;
      so_q   <= so_d;
    end
  end

  // R2: a freshly loaded byte presents its MSB first
  p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (so == $past(tx_byte[7])));

endmodule

// File: rtl/sfl_busy.sv
module sfl_busy #(
  parameter int BUSY_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (start)
      cnt_d = CW'(BUSY_CYC);
    else if (busy)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: an accepted operation makes the block busy on the next clock
  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> busy);

  // R8: the completion pulse ends the busy period
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

endmodule

// File: rtl/sfl_array.sv
module sfl_array #(
  parameter int SECT_AW  = 4,
  parameter int NSECT_AW = 5,
  localparam int AW      = SECT_AW + NSECT_AW,
  localparam int DEPTH   = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          prog_en,
  input  logic          sect_en,
  input  logic          chip_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);

  logic [7:0] mem [DEPTH];
  logic       tgt_blank;

  assign rd_data   = mem[rd_addr];
  assign tgt_blank = (mem[wr_addr] == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (chip_en) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (sect_en) begin
      for (int i = 0; i < DEPTH; i++)
        if ((AW'(i) >> SECT_AW) == (wr_addr >> SECT_AW)) mem[i] <= 8'hFF;
    end else if (prog_en && tgt_blank) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // R6: chip erase leaves both ends of the array blank
  p_chip_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

  // R4: programming a non-blank byte leaves it untouched
  p_prog_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !sect_en && !chip_en && !tgt_blank) |=> $stable(mem[wr_addr]));

endmodule

// File: rtl/sfl_slave.sv
module sfl_slave
  import sfl_pkg::*;
#(
  parameter int SECT_AW  = 4,
  parameter int NSECT_AW = 5,
  parameter int BUSY_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe,
  input  logic wp_n,
  input  logic dev_rst_n
);

  localparam int AW = SECT_AW + NSECT_AW;

  logic cs_s, sck_s, si_s, wp_s, hw_s;
  logic byte_vld, cs_fall, cs_rise, tx_load, tx_en;
  logic [7:0] byte_out, tx_byte, rd_data;
  logic busy, done, op_start, clr;

  cmd_st_e       st_q, st_d;
  logic [7:0]    opc_q, opc_d;
  logic [1:0]    acnt_q, acnt_d;
  logic [AW-1:0] addr_q, addr_d, addr_new;
  logic [AW-1:0] ptr_q, ptr_d;
  job_e          job_q, job_d;
  logic [AW-1:0] paddr_q, paddr_d;
  logic [7:0]    pdata_q, pdata_d;

  sfl_sync #(.W(5), .RST_VAL(5'b10011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sck, si, wp_n, dev_rst_n}),
    .q     ({cs_s, sck_s, si_s, wp_s, hw_s})
  );

  sfl_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cs_s     (cs_s),
    .si_s     (si_s),
    .tx_en    (tx_en),
    .tx_byte  (tx_byte),
    .byte_vld (byte_vld),
    .byte_out (byte_out),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .tx_load  (tx_load),
    .so       (so)
  );

  sfl_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (op_start),
    .clr   (clr),
    .busy  (busy),
    .done  (done)
  );

  sfl_array #(.SECT_AW(SECT_AW), .NSECT_AW(NSECT_AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (ptr_q),
    .rd_data (rd_data),
    .prog_en (done && job_q == JOB_PROG),
    .sect_en (done && job_q == JOB_SECT),
    .chip_en (done && job_q == JOB_CHIP),
    .wr_addr (paddr_q),
    .wr_data (pdata_q)
  );

  assign tx_en    = (st_q == ST_READ) || (st_q == ST_STAT);
  assign tx_byte  = (st_q == ST_STAT) ? {7'd0, busy} : rd_data;
  assign so_oe    = tx_en && !cs_s;
  assign addr_new = AW'({addr_q, byte_out});

  always_comb begin
    st_d     = st_q;
    opc_d    = opc_q;
    acnt_d   = acnt_q;
    addr_d   = addr_q;
    ptr_d    = ptr_q;
    job_d    = job_q;
    paddr_d  = paddr_q;
    pdata_d  = pdata_q;
    op_start = 1'b0;
    clr      = 1'b0;
    if (tx_load && st_q == ST_READ) ptr_d = ptr_q + AW'(1);
    if (!hw_s) begin
      st_d  = ST_IDLE;
      clr   = 1'b1;
      job_d = JOB_NONE;
    end else if (cs_rise) begin
      st_d = ST_IDLE;
    end else if (cs_fall) begin
      st_d = ST_OPC;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_OPC: begin
          opc_d  = byte_out;
          acnt_d = 2'd0;
          unique case (byte_out)
            OPC_READ:   st_d = busy ? ST_IGN : ST_ADDR;
            OPC_STAT:   st_d = ST_STAT;
            OPC_PROG,
            OPC_SERASE: st_d = (busy || !wp_s) ? ST_IGN : ST_ADDR;
            OPC_CERASE: begin
              st_d = ST_IGN;
              if (!busy && wp_s) begin
                op_start = 1'b1;
                job_d    = JOB_CHIP;
              end
            end
            default:    st_d = ST_IGN;
          endcase
        end
        ST_ADDR: begin
          addr_d = addr_new;
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            unique case (opc_q)
              OPC_READ: begin
                st_d  = ST_READ;
                ptr_d = addr_new;
              end
              OPC_PROG: st_d = ST_DATA;
              default: begin
                st_d = ST_IGN;
                if (wp_s) begin
                  op_start = 1'b1;
                  job_d    = JOB_SECT;
                  paddr_d  = addr_new;
                end
              end
            endcase
          end
        end
        ST_DATA: begin
          st_d = ST_IGN;
          if (wp_s) begin
            op_start = 1'b1;
            job_d    = JOB_PROG;
            paddr_d  = addr_q;
            pdata_d  = byte_out;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      opc_q   <= 8'd0;
      acnt_q  <= 2'd0;
      addr_q  <= '0;
      ptr_q   <= '0;
      job_q   <= JOB_NONE;
      paddr_q <= '0;
      pdata_q <= 8'd0;
    end else begin
      st_q    <= st_d;
      opc_q   <= opc_d;
      acnt_q  <= acnt_d;
      addr_q  <= addr_d;
      ptr_q   <= ptr_d;
      job_q   <= job_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  // R8: a new operation never starts on top of a running one
  p_start_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !busy);

  // R9: nothing starts while write protect is active
  p_start_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> wp_s);

  // R12: output enable drops once select has risen
  p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !so_oe);

  // R12: device reset forces standby and clears busy
  p_hw_standby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_s |=> (st_q == ST_IDLE && !busy));

  // R11: ignored commands keep the output off
  p_ign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN) |-> !so_oe);

endmodule

// File: tb/sfl_slave_test.sv
module sfl_slave_test;

  localparam int SECT_AW  = 4;
  localparam int NSECT_AW = 5;
  localparam int BUSY     = 300;
  localparam int DEPTH    = 1 << (SECT_AW + NSECT_AW);

  logic clk, rst_n, cs_n, sck, si, wp_n, dev_rst_n;
  logic so, so_oe;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [7:0] mem_m [DEPTH];
  bit busy_m = 0;
  bit wp_m = 1;
  int hi_cnt = 0;

  sfl_slave #(.SECT_AW(SECT_AW), .NSECT_AW(NSECT_AW), .BUSY_CYC(BUSY)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .si        (si),
    .so        (so),
    .so_oe     (so_oe),
    .wp_n      (wp_n),
    .dev_rst_n (dev_rst_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R12: select high for a few clocks means output enable off, checked each clock
  always @(negedge clk) begin
    if (rst_n && cs_n) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt >= 4 && !finished) check(so_oe == 1'b0, "R12 oe while deselected", so_oe, 0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic b, output logic s, output logic oe);
    s  = so;
    oe = so_oe;
    si = b;
    tick(2);
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(4);
  endtask

  task automatic send(input logic [7:0] v);
    logic s, oe;
    for (int i = 7; i >= 0; i--) xfer(v[i], s, oe);
  endtask

  task automatic recv(output logic [7:0] v, output bit oe_all);
    logic s, oe;
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      xfer(1'b0, s, oe);
      v[i] = s;
      if (oe !== 1'b1) oe_all = 0;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic desel;
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic send_addr(input int a);
    send(8'(a >> 16));
    send(8'(a >> 8));
    send(8'(a));
  endtask

  task automatic do_prog(input int a, input logic [7:0] d);
    sel(); send(8'h02); send_addr(a); send(d); desel();
    if (!busy_m && wp_m) begin
      busy_m = 1;
      if (mem_m[a] == 8'hFF) mem_m[a] = d;
    end
  endtask

  task automatic do_sect(input int a);
    sel(); send(8'h20); send_addr(a); desel();
    if (!busy_m && wp_m) begin
      busy_m = 1;
      for (int i = 0; i < DEPTH; i++)
        if ((i >> SECT_AW) == (a >> SECT_AW)) mem_m[i] = 8'hFF;
    end
  endtask

  task automatic do_chip;
    sel(); send(8'h60); desel();
    if (!busy_m && wp_m) begin
      busy_m = 1;
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    end
  endtask

  task automatic settle;
    tick(BUSY + 50);
    busy_m = 0;
  endtask

  task automatic read_chk(input int a, input int n, input string tag);
    logic [7:0] v;
    bit oe;
    sel(); send(8'h03); send_addr(a);
    for (int k = 0; k < n; k++) begin
      recv(v, oe);
      check(v == mem_m[(a + k) % DEPTH], tag, v, mem_m[(a + k) % DEPTH]);
      check(oe, {tag, " oe"}, oe, 1);
    end
    desel();
  endtask

  task automatic stat_chk(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bit oe;
    sel(); send(8'h05); recv(v, oe); desel();
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, prev;
    bit oe, mono;
    logic s, o;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    rst_n = 0; cs_n = 1; sck = 0; si = 0; wp_n = 1; dev_rst_n = 1;
    tick(5);
    rst_n = 1;
    tick(5);

    // R13: reset state
    check(so_oe == 1'b0, "R13 oe after reset", so_oe, 0);
    stat_chk(8'h00, "R13 status after reset");
    read_chk(5, 3, "R13 blank array / R2 read");

    // R1 R4 R7 R8: program, busy visible, then applied
    do_prog(16, 8'hA5);
    stat_chk(8'h01, "R7 R8 busy during program");
    settle();
    stat_chk(8'h00, "R7 ready after program");
    read_chk(16, 1, "R1 R4 programmed byte");

    // R4: not blank, stays
    do_prog(16, 8'h3C); settle();
    read_chk(16, 1, "R4 program on non-blank");

    // R5: sector erase
    do_prog(17, 8'h5A); settle();
    do_prog(31, 8'h12); settle();
    do_prog(32, 8'h77); settle();
    do_sect(24); settle();
    read_chk(15, 19, "R5 sector erase");

    // R8: commands ignored while busy
    do_prog(48, 8'h11);
    do_prog(49, 8'h22);
    settle();
    do_prog(50, 8'h33);
    sel(); send(8'h03); send_addr(48); recv(v, oe); desel();
    check(oe == 0, "R8 read ignored while busy", oe, 0);
    settle();
    read_chk(48, 3, "R8 results after busy");

    // R9: write protect
    wp_n = 0; wp_m = 0; tick(4);
    do_prog(64, 8'h99);
    stat_chk(8'h00, "R9 no busy under protect");
    do_chip();
    stat_chk(8'h00, "R9 chip erase blocked");
    read_chk(63, 3, "R9 array unchanged");
    wp_n = 1; wp_m = 1; tick(4);

    // R10: abort mid data byte
    sel(); send(8'h02); send_addr(65);
    for (int i = 0; i < 4; i++) xfer(1'b0, s, o);
    desel();
    stat_chk(8'h00, "R10 aborted program not busy");
    read_chk(65, 1, "R10 aborted program");

    // R11: unknown opcode
    sel(); send(8'hAB); send(8'h00); recv(v, oe); desel();
    check(oe == 0, "R11 unknown opcode output off", oe, 0);
    stat_chk(8'h00, "R11 unknown opcode no busy");

    // R3: wrap at top of array
    do_prog(DEPTH - 1, 8'hC3); settle();
    do_prog(0, 8'h3C); settle();
    read_chk(DEPTH - 2, 4, "R3 read wrap");

    // R12: device reset cancels pending program
    do_prog(80, 8'h66);
    dev_rst_n = 0; tick(6); dev_rst_n = 1; tick(4);
    mem_m[80] = 8'hFF;
    busy_m = 0;
    stat_chk(8'h00, "R12 reset clears busy");
    tick(BUSY + 50);
    read_chk(80, 1, "R12 reset discards program");

    // R7 R8: continuous status across busy expiry
    do_prog(96, 8'h01);
    sel(); send(8'h05);
    mono = 1; prev = 8'h01;
    for (int k = 0; k < 8; k++) begin
      recv(v, oe);
      if (k == 0) check(v == 8'h01, "R7 first streamed status", v, 1);
      if (!(v == 8'h00 || v == 8'h01) || v > prev) mono = 0;
      prev = v;
    end
    desel();
    check(mono, "R7 R8 status stream monotonic", mono, 1);
    check(prev == 8'h00, "R8 status stream ends ready", prev, 0);
    busy_m = 0;
    read_chk(96, 1, "R4 program after stream");

    // R6: chip erase
    do_chip();
    stat_chk(8'h01, "R6 chip erase busy");
    settle();
    read_chk(DEPTH - 2, 4, "R6 chip erase");
    read_chk(30, 4, "R6 chip erase middle");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule